// File: doc/BRIEF.md
# Tamper and Environmental Response Controller

This controller sits beside a small bank of secret-key registers and acts on debounced digital flags from the environmental and tamper sensors. Each supply rail, the temperature sensor, the battery monitor, a radiation detector and a protective membrane report status bits. The controller sorts every active condition into one of three classes. An excursion that can be recovered from holds the system in reset. A battery that is getting weak raises a warning. A condition that points to damage or attack latches a tamper event.

A tamper event wipes the key bank one word per clock. From the cycle the condition appears, key reads return zero. The event also records which condition classes caused it. The tamper flag and its cause survive every system reset and clear only on an authorized clear pulse, and only once the wipe is complete and no tamper condition is still present. Each sensed quantity has two nested limits: leaving the wide operating window only resets, while leaving the damage window tampers.

Top module: `tamper_resp_ctrl`

## Requirements
- R1: Any rail with its operating-window flag set drives `sysReset` high from the next clock edge and does not set `tamperFlag`.
- R2: Any rail with its damage-window flag set sets `tamperFlag` at the next clock edge.
- R3: `battLow` drives `warnIrq` high one clock later and affects neither `sysReset`, `tamperFlag` nor key access.
- R4: `battFail` sets `tamperFlag` at the next clock edge.
- R5: `tempOutOper` drives `sysReset` like R1, and `tempOutDmg` sets `tamperFlag` at the next clock edge.
- R6: `radDetect` sets `tamperFlag` at the next clock edge.
- R7: `meshBreach` sets `tamperFlag` at the next clock edge.
- R8: `tamperFlag` is sticky. Only the power-on reset `rstN` or a `clearAuth` pulse clears it. `clearAuth` takes effect only while `zeroDone` is high and no tamper condition is active. `sysReset` has no effect on it.
- R9: Once `tamperFlag` is set, `zeroStrobe` is high for exactly NUM_KEYS consecutive clocks, one word being cleared per clock. `zeroDone` then rises and stays high until the clear. Key writes are ignored while `tamperFlag` is set. After the clear, every word reads zero.
- R10: `keyRdData` is zero in the same cycle that any tamper condition input is active, and at all times while `tamperFlag` is set.
- R11: `sysReset` is high while `rstN` is low. It stays high for 15 rising edges after every operating-window flag has returned in range, and falls on the 16th.
- R12: `causeReg` latches the classes active on the edge that sets `tamperFlag`, using these bits: bit0 supply, bit1 battery, bit2 temperature, bit3 radiation, bit4 membrane. Later conditions do not change it. It is kept after the wipe and is cleared together with `tamperFlag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| railOutOper | input | NUM_RAILS | Per rail: outside its operating window |
| railOutDmg | input | NUM_RAILS | Per rail: outside its damage window |
| battLow | input | 1 | Battery low |
| battFail | input | 1 | Battery failed |
| tempOutOper | input | 1 | Temperature outside its operating window |
| tempOutDmg | input | 1 | Temperature outside its damage window |
| radDetect | input | 1 | Radiation detected |
| meshBreach | input | 1 | Membrane breach or fault |
| clearAuth | input | 1 | Authorized clear pulse for the tamper state |
| keyWrEn | input | 1 | Key word write enable |
| keyWrAddr | input | ADDR_W | Key word write index |
| keyWrData | input | KEY_W | Key word write data |
| keyRdAddr | input | ADDR_W | Key word read index |
| keyRdData | output | KEY_W | Key word read data, combinational, zero while locked |
| sysReset | output | 1 | System reset request |
| warnIrq | output | 1 | Battery warning interrupt |
| tamperFlag | output | 1 | Latched tamper event |
| zeroStrobe | output | 1 | High in each clock in which a key word is cleared |
| zeroDone | output | 1 | Wipe complete |
| causeReg | output | 5 | First-tamper cause classes |

## Verification
The bench covers the boundary between the two windows. An operating-only excursion must reset without tampering, and a design that mixed up the windows would either wipe keys on a brownout or never react to damage. It counts wipe strobes and then reads every word after the clear, so a wipe that stops one word short, or writes that slip through during the lock, show up as nonzero data. It also targets the stickiness rules: a clear issued mid-wipe or while a condition is still active, a system reset during tamper, and a second tamper after the first. A design that rearmed the cause register or let reset clear the flag would lose the record of the first event. The reset hold is sampled one edge before and one edge after its expected release.

// File: rtl/tamper_pkg.sv
package tamper_pkg;
  localparam int CAUSE_W      = 5;
  localparam int CAUSE_SUPPLY = 0;
  localparam int CAUSE_BATT   = 1;
  localparam int CAUSE_TEMP   = 2;
  localparam int CAUSE_RAD    = 3;
  localparam int CAUSE_MESH   = 4;

  typedef enum logic [1:0] {
    WIPE_IDLE,
    WIPE_RUN,
    WIPE_DONE
  } wipe_state_t;

  // strobes from control to the key datapath
  typedef struct packed {
    logic wipe;   // clear the addressed word this cycle
    logic lock;   // block writes, force reads to zero
  } bank_cmd_t;
endpackage

// File: rtl/tamper_classify.sv
module tamper_classify
  import tamper_pkg::*;
#(
  parameter int NUM_RAILS = 3
) (
  input  logic [NUM_RAILS-1:0] railOutOper,
  input  logic [NUM_RAILS-1:0] railOutDmg,
  input  logic                 battFail,
  input  logic                 tempOutOper,
  input  logic                 tempOutDmg,
  input  logic                 radDetect,
  input  logic                 meshBreach,
  output logic [CAUSE_W-1:0]   hitVec,
  output logic                 anyHit,
  output logic                 operOut
);
  always_comb begin
    hitVec               = '0;
    hitVec[CAUSE_SUPPLY] = |railOutDmg;
    hitVec[CAUSE_BATT]   = battFail;
    hitVec[CAUSE_TEMP]   = tempOutDmg;
    hitVec[CAUSE_RAD]    = radDetect;
    hitVec[CAUSE_MESH]   = meshBreach;
  end

  assign anyHit  = |hitVec;
  assign operOut = (|railOutOper) | tempOutOper;
endmodule

// File: rtl/tamper_ctrl.sv
module tamper_ctrl
  import tamper_pkg::*;
#(
  parameter int NUM_KEYS = 8,
  parameter int RST_HOLD = 16,
  localparam int IDX_W   = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1,
  localparam int HOLD_W  = $clog2(RST_HOLD + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CAUSE_W-1:0] hitVec,
  input  logic               anyHit,
  input  logic               operOut,
  input  logic               battLow,
  input  logic               clearAuth,
  output bank_cmd_t          bankCmd,
  output logic [IDX_W-1:0]   wipeIdx,
  output logic               sysReset,
  output logic               warnIrq,
  output logic               tamperFlag,
  output logic               zeroStrobe,
  output logic               zeroDone,
  output logic [CAUSE_W-1:0] causeReg
);
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(NUM_KEYS - 1);
  localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(RST_HOLD);

  wipe_state_t       wipeState;
  logic [HOLD_W-1:0] holdCnt;
  logic              clearOk;

  assign clearOk = clearAuth && (wipeState == WIPE_DONE) && !anyHit;

  // reset stretcher
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= HOLD_LOAD;
      warnIrq <= 1'b0;
    end else begin
      warnIrq <= battLow;
      if (operOut)
        holdCnt <= HOLD_LOAD;
      else if (holdCnt != '0)
        holdCnt <= holdCnt - 1'b1;
    end
  end

  // tamper latch and wipe sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tamperFlag <= 1'b0;
      causeReg   <= '0;
      wipeState  <= WIPE_IDLE;
      wipeIdx    <= '0;
    end else if (anyHit && !tamperFlag) begin
      tamperFlag <= 1'b1;
      causeReg   <= hitVec;
      wipeState  <= WIPE_RUN;
      wipeIdx    <= '0;
    end else if (clearOk) begin
      tamperFlag <= 1'b0;
      causeReg   <= '0;
      wipeState  <= WIPE_IDLE;
      wipeIdx    <= '0;
    end else if (wipeState == WIPE_RUN) begin
      if (wipeIdx == LAST_IDX)
        wipeState <= WIPE_DONE;
      else
        wipeIdx <= wipeIdx + 1'b1;
    end
  end

  assign sysReset     = (holdCnt != '0);
  assign zeroStrobe   = (wipeState == WIPE_RUN);
  assign zeroDone     = (wipeState == WIPE_DONE);
  assign bankCmd.wipe = zeroStrobe;
  assign bankCmd.lock = tamperFlag | anyHit;
endmodule

// File: rtl/key_bank.sv
module key_bank
  import tamper_pkg::*;
#(
  parameter int NUM_KEYS = 8,
  parameter int KEY_W    = 32,
  localparam int IDX_W   = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  bank_cmd_t        bankCmd,
  input  logic [IDX_W-1:0] wipeIdx,
  input  logic             keyWrEn,
  input  logic [IDX_W-1:0] keyWrAddr,
  input  logic [KEY_W-1:0] keyWrData,
  input  logic [IDX_W-1:0] keyRdAddr,
  output logic [KEY_W-1:0] keyRdData
);
  logic [KEY_W-1:0] keyWord [NUM_KEYS];

  for (genvar w = 0; w < NUM_KEYS; w++) begin : g_word
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        keyWord[w] <= '0;
      else if (bankCmd.wipe && (wipeIdx == IDX_W'(w)))
        keyWord[w] <= '0;
      else if (keyWrEn && !bankCmd.lock && (keyWrAddr == IDX_W'(w)))
        keyWord[w] <= keyWrData;
    end
  end

  assign keyRdData = bankCmd.lock ? '0 : keyWord[keyRdAddr];
endmodule

// File: rtl/tamper_resp_ctrl.sv
module tamper_resp_ctrl
  import tamper_pkg::*;
#(
  parameter int NUM_RAILS = 3,
  parameter int NUM_KEYS  = 8,
  parameter int KEY_W     = 32,
  parameter int RST_HOLD  = 16,
  localparam int ADDR_W   = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_RAILS-1:0] railOutOper,
  input  logic [NUM_RAILS-1:0] railOutDmg,
  input  logic                 battLow,
  input  logic                 battFail,
  input  logic                 tempOutOper,
  input  logic                 tempOutDmg,
  input  logic                 radDetect,
  input  logic                 meshBreach,
  input  logic                 clearAuth,
  input  logic                 keyWrEn,
  input  logic [ADDR_W-1:0]    keyWrAddr,
  input  logic [KEY_W-1:0]     keyWrData,
  input  logic [ADDR_W-1:0]    keyRdAddr,
  output logic [KEY_W-1:0]     keyRdData,
  output logic                 sysReset,
  output logic                 warnIrq,
  output logic                 tamperFlag,
  output logic                 zeroStrobe,
  output logic                 zeroDone,
  output logic [4:0]           causeReg
);
  logic [CAUSE_W-1:0] hitVec;
  logic               anyHit;
  logic               operOut;
  bank_cmd_t          bankCmd;
  logic [ADDR_W-1:0]  wipeIdx;

  tamper_classify #(.NUM_RAILS(NUM_RAILS)) i_classify (
    .railOutOper (railOutOper),
    .railOutDmg  (railOutDmg),
    .battFail    (battFail),
    .tempOutOper (tempOutOper),
    .tempOutDmg  (tempOutDmg),
    .radDetect   (radDetect),
    .meshBreach  (meshBreach),
    .hitVec      (hitVec),
    .anyHit      (anyHit),
    .operOut     (operOut)
  );

  tamper_ctrl #(.NUM_KEYS(NUM_KEYS), .RST_HOLD(RST_HOLD)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hitVec     (hitVec),
    .anyHit     (anyHit),
    .operOut    (operOut),
    .battLow    (battLow),
    .clearAuth  (clearAuth),
    .bankCmd    (bankCmd),
    .wipeIdx    (wipeIdx),
    .sysReset   (sysReset),
    .warnIrq    (warnIrq),
    .tamperFlag (tamperFlag),
    .zeroStrobe (zeroStrobe),
    .zeroDone   (zeroDone),
    .causeReg   (causeReg)
  );

  key_bank #(.NUM_KEYS(NUM_KEYS), .KEY_W(KEY_W)) i_bank (
    .clk       (clk),
    .rstN      (rstN),
    .bankCmd   (bankCmd),
    .wipeIdx   (wipeIdx),
    .keyWrEn   (keyWrEn),
    .keyWrAddr (keyWrAddr),
    .keyWrData (keyWrData),
    .keyRdAddr (keyRdAddr),
    .keyRdData (keyRdData)
  );
endmodule

// File: rtl/tamper_resp_chk.sv
module tamper_resp_chk #(
  parameter int NUM_RAILS = 3,
  parameter int NUM_KEYS  = 8,
  parameter int KEY_W     = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_RAILS-1:0] railOutOper,
  input logic [NUM_RAILS-1:0] railOutDmg,
  input logic                 battFail,
  input logic                 tempOutOper,
  input logic                 tempOutDmg,
  input logic                 radDetect,
  input logic                 meshBreach,
  input logic                 clearAuth,
  input logic [KEY_W-1:0]     keyRdData,
  input logic                 sysReset,
  input logic                 tamperFlag,
  input logic                 zeroStrobe,
  input logic                 zeroDone,
  input logic [4:0]           causeReg
);
  localparam int CNT_W = $clog2(NUM_KEYS + 1) + 1;
  logic [CNT_W-1:0] strobeCnt;
  logic             condNow;

  assign condNow = (|railOutDmg) | battFail | tempOutDmg | radDetect | meshBreach;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      strobeCnt <= '0;
    else if (!tamperFlag)
      strobeCnt <= '0;
    else if (zeroStrobe)
      strobeCnt <= strobeCnt + 1'b1;
  end

  // R1 / R5
  a_r1_oper_resets: assert property (@(posedge clk) disable iff (!rstN)
    ((|railOutOper) | tempOutOper) |=> sysReset);
  // R2 R4 R5 R6 R7
  a_r2_cond_tampers: assert property (@(posedge clk) disable iff (!rstN)
    condNow |=> tamperFlag);
  // R8
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (tamperFlag && !clearAuth) |=> tamperFlag);
  // R9
  a_r9_strobe_count: assert property (@(posedge clk) disable iff (!rstN)
    $rose(zeroDone) |-> (strobeCnt == CNT_W'(NUM_KEYS)));
  a_r9_strobe_under_flag: assert property (@(posedge clk) disable iff (!rstN)
    zeroStrobe |-> (tamperFlag && !zeroDone));
  // R10
  a_r10_read_locked: assert property (@(posedge clk) disable iff (!rstN)
    (tamperFlag || condNow) |-> (keyRdData == '0));
  // R12
  a_r12_cause_held: assert property (@(posedge clk) disable iff (!rstN)
    (tamperFlag && !clearAuth) |=> $stable(causeReg));
  a_r12_cause_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    tamperFlag |-> (causeReg != '0));
endmodule

bind tamper_resp_ctrl tamper_resp_chk #(
  .NUM_RAILS(NUM_RAILS), .NUM_KEYS(NUM_KEYS), .KEY_W(KEY_W)
) i_chk (
  .clk(clk), .rstN(rstN), .railOutOper(railOutOper), .railOutDmg(railOutDmg),
  .battFail(battFail), .tempOutOper(tempOutOper), .tempOutDmg(tempOutDmg),
  .radDetect(radDetect), .meshBreach(meshBreach), .clearAuth(clearAuth),
  .keyRdData(keyRdData), .sysReset(sysReset), .tamperFlag(tamperFlag),
  .zeroStrobe(zeroStrobe), .zeroDone(zeroDone), .causeReg(causeReg)
);

// File: tb/test_tamper_resp_ctrl.sv
module test_tamper_resp_ctrl;
  localparam int NR = 3;
  localparam int NK = 8;
  localparam int KW = 32;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NR-1:0] railOutOper = '0, railOutDmg = '0;
  logic          battLow = 0, battFail = 0, tempOutOper = 0, tempOutDmg = 0;
  logic          radDetect = 0, meshBreach = 0, clearAuth = 0;
  logic          keyWrEn = 0;
  logic [AW-1:0] keyWrAddr = '0, keyRdAddr = '0;
  logic [KW-1:0] keyWrData = '0;
  logic [KW-1:0] keyRdData;
  logic          sysReset, warnIrq, tamperFlag, zeroStrobe, zeroDone;
  logic [4:0]    causeReg;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  tamper_resp_ctrl #(.NUM_RAILS(NR), .NUM_KEYS(NK), .KEY_W(KW)) i_tamper_resp_ctrl (
    .clk(clk), .rstN(rstN), .railOutOper(railOutOper), .railOutDmg(railOutDmg),
    .battLow(battLow), .battFail(battFail), .tempOutOper(tempOutOper),
    .tempOutDmg(tempOutDmg), .radDetect(radDetect), .meshBreach(meshBreach),
    .clearAuth(clearAuth), .keyWrEn(keyWrEn), .keyWrAddr(keyWrAddr),
    .keyWrData(keyWrData), .keyRdAddr(keyRdAddr), .keyRdData(keyRdData),
    .sysReset(sysReset), .warnIrq(warnIrq), .tamperFlag(tamperFlag),
    .zeroStrobe(zeroStrobe), .zeroDone(zeroDone), .causeReg(causeReg)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setCond(input int cls, input logic v);
    case (cls)
      0: railOutDmg[2] = v;
      1: battFail      = v;
      2: tempOutDmg    = v;
      3: radDetect     = v;
      default: meshBreach = v;
    endcase
  endtask

  task automatic readKey(input int a, output logic [KW-1:0] d);
    keyRdAddr = AW'(a);
    #1 d = keyRdData;
  endtask

  task automatic loadKeys();
    logic [KW-1:0] d;
    for (int i = 0; i < NK; i++) begin
      keyWrEn = 1; keyWrAddr = AW'(i); keyWrData = 32'hA500_0000 + i;
      cyc(1);
    end
    keyWrEn = 0;
    readKey(3, d);
    check("R9 key load", d, 32'hA500_0003);
  endtask

  task automatic doClear();
    clearAuth = 1; cyc(1); clearAuth = 0;
  endtask

  task automatic testReset();
    cyc(2);
    check("R11 reset during por", sysReset, 1);
    check("R8 flag at reset", tamperFlag, 0);
    check("R12 cause at reset", causeReg, 0);
    check("R3 warn at reset", warnIrq, 0);
    rstN = 1;
    cyc(15);
    check("R11 hold after por 15", sysReset, 1);
    cyc(1);
    check("R11 release after por 16", sysReset, 0);
  endtask

  task automatic testOperRail();
    railOutOper[1] = 1; cyc(1);
    check("R1 rail reset", sysReset, 1);
    check("R1 no tamper", tamperFlag, 0);
    cyc(3);
    railOutOper[1] = 0;
    cyc(15);
    check("R11 hold 15", sysReset, 1);
    cyc(1);
    check("R11 release 16", sysReset, 0);
    check("R1 still no tamper", tamperFlag, 0);
  endtask

  task automatic testTempOper();
    tempOutOper = 1; cyc(1);
    check("R5 temp reset", sysReset, 1);
    check("R5 temp no tamper", tamperFlag, 0);
    tempOutOper = 0; cyc(16);
    check("R5 temp release", sysReset, 0);
  endtask

  task automatic testBattLow();
    logic [KW-1:0] d;
    loadKeys();
    battLow = 1; cyc(1);
    check("R3 warn", warnIrq, 1);
    check("R3 no reset", sysReset, 0);
    check("R3 no tamper", tamperFlag, 0);
    readKey(5, d);
    check("R3 keys readable", d, 32'hA500_0005);
    battLow = 0; cyc(1);
    check("R3 warn drops", warnIrq, 0);
  endtask

  task automatic runTamper(input int cls, input string req);
    logic [KW-1:0] d;
    int strobes;
    loadKeys();
    setCond(cls, 1);
    readKey(1, d);
    check({req, " R10 same cycle read"}, d, 0);
    cyc(1);
    check({req, " tamper"}, tamperFlag, 1);
    check({req, " R12 cause"}, causeReg, 64'(1 << cls));
    setCond(cls, 0);
    strobes = 0;
    for (int i = 0; i < NK; i++) begin
      if (zeroStrobe) strobes++;
      cyc(1);
    end
    check({req, " R9 strobe count"}, strobes, NK);
    check({req, " R9 done"}, zeroDone, 1);
    check({req, " R9 strobe off"}, zeroStrobe, 0);
    keyWrEn = 1; keyWrAddr = 0; keyWrData = 32'hDEAD_BEEF; cyc(1); keyWrEn = 0;
    readKey(0, d);
    check({req, " R10 locked read"}, d, 0);
    check({req, " R12 cause kept"}, causeReg, 64'(1 << cls));
    doClear();
    check({req, " R8 cleared"}, tamperFlag, 0);
    check({req, " R12 cause cleared"}, causeReg, 0);
    for (int i = 0; i < NK; i++) begin
      readKey(i, d);
      check({req, " R9 wiped word"}, d, 0);
    end
  endtask

  task automatic testSticky();
    meshBreach = 1; cyc(1); meshBreach = 0;
    cyc(1);
    doClear();
    check("R8 clear mid-wipe ignored", tamperFlag, 1);
    cyc(NK);
    check("R9 done before clear", zeroDone, 1);
    railOutOper[0] = 1; cyc(3); railOutOper[0] = 0;
    cyc(20);
    check("R8 flag survives sysReset", tamperFlag, 1);
    radDetect = 1; cyc(1);
    doClear();
    check("R8 clear with active cond ignored", tamperFlag, 1);
    check("R12 cause unchanged by later", causeReg, 5'b10000);
    radDetect = 0; cyc(1);
    doClear();
    check("R8 clear accepted", tamperFlag, 0);
  endtask

  task automatic testSimul();
    radDetect = 1; meshBreach = 1; battFail = 1; cyc(1);
    radDetect = 0; meshBreach = 0; battFail = 0;
    check("R12 simultaneous cause", causeReg, 5'b11010);
    tempOutDmg = 1; cyc(1); tempOutDmg = 0;
    check("R12 first cause held", causeReg, 5'b11010);
    cyc(NK + 1);
    doClear();
    check("R12 clear", causeReg, 0);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    testReset();
    testOperRail();
    testTempOper();
    testBattLow();
    runTamper(0, "R2");
    runTamper(1, "R4");
    runTamper(2, "R5");
    runTamper(3, "R6");
    runTamper(4, "R7");
    testSticky();
    testSimul();
    summary();
  end
endmodule